// File: doc/BRIEF.md
# Timer Compare and PWM Output Channel

This block is one output channel that watches a free-running timer count and drives a single output pin. It does not own a timer. Two timer count buses come in from outside, each with a strobe that pulses on the count's last value before rollover. A select bit picks which of the two time bases the channel compares against.

A 3-bit mode field sets the channel's behaviour. In the single-match modes the pin is set, cleared or inverted when the count equals the primary compare value. In the dual-match modes the pin rises on the primary value and falls on the secondary value, either once or once in every timer period. In the PWM modes the pin rises at each rollover and falls when the count reaches a buffered duty value. One PWM variant also watches a fault input and, when it fires, holds the pin low until software changes the mode field.

The channel raises a one-cycle interrupt pulse on its compare events. A sticky fault indication is also brought out.

Top module: `cmp_pwm_chan`

## Requirements
- R1: When `base_sel` is 0 the channel compares against `tmr0_cnt` and `tmr0_wrap`. When it is 1 it uses `tmr1_cnt` and `tmr1_wrap`.
- R2: Mode code 000 is off. One clock after 000 is sampled, `pin_out` and `match_irq` are 0. Reset leaves `pin_out`, `match_irq` and `fault_flag` at 0.
- R3: When the sampled `mode_sel` differs from its value on the previous clock, the channel ignores all matches for that clock. It then sets `pin_out` to 1 for code 010 and to 0 for every other code, clears `fault_flag` and the single-pulse state, and loads `cmp_pri` as the duty value.
- R4: Code 001: a primary match (count equal to `cmp_pri`) sets `pin_out` to 1 and pulses `match_irq`.
- R5: Code 010: a primary match clears `pin_out` to 0 and pulses `match_irq`.
- R6: Code 011: a primary match inverts `pin_out` and pulses `match_irq`.
- R7: Codes 100 and 101: a primary match sets `pin_out`. A secondary match (count equal to `cmp_sec`) clears it, and it pulses `match_irq` if the pin was high. If both values match on the same clock, the secondary match wins.
- R8: Code 100 produces only one pulse after entry. Code 101 produces a new pulse in every timer period.
- R9: Codes 110 and 111: on a period strobe the pin is set to 1, or held at 0 if the new duty value is 0, and `match_irq` pulses. On any other clock, a count equal to the active duty value clears the pin.
- R10: A new `cmp_pri` value written while a PWM mode runs becomes the active duty value only at the next period strobe.
- R11: Code 111: when `fault_in` is high, `pin_out` is forced to 0 and `fault_flag` is set. Both stay that way, and the period strobe is ignored, until the mode field changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr0_cnt | input | W | Count of time base 0 |
| tmr0_wrap | input | 1 | Last-count strobe of time base 0 |
| tmr1_cnt | input | W | Count of time base 1 |
| tmr1_wrap | input | 1 | Last-count strobe of time base 1 |
| mode_sel | input | 3 | Operating mode code |
| base_sel | input | 1 | Time base select |
| cmp_pri | input | W | Primary compare value, also the PWM duty value |
| cmp_sec | input | W | Secondary compare value |
| fault_in | input | 1 | Fault input, active high, used in code 111 |
| pin_out | output | 1 | Channel output pin |
| match_irq | output | 1 | Compare event pulse |
| fault_flag | output | 1 | Sticky fault indication |

## Verification
All three outputs are registered. Each one reflects the inputs sampled on a rising edge from that same edge onward, so every result is due exactly one clock after its stimulus. A mode change adds one clock of initialisation before the first match can act, and the release of reset adds two clocks of internal synchronisation. The bench's predictor samples the inputs on each rising edge and pushes the expected pin, interrupt and fault values for that edge into a queue. The monitor pops each entry on the following falling edge, so every comparison lands exactly one registered stage after its stimulus.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic [2:0] {
    MD_OFF  = 3'b000,
    MD_SET  = 3'b001,
    MD_CLR  = 3'b010,
    MD_TGL  = 3'b011,
    MD_ONE  = 3'b100,
    MD_RPT  = 3'b101,
    MD_PWM  = 3'b110,
    MD_PWMF = 3'b111
  } cmp_mode_e;

  localparam int NUM_BASES = 2;
  localparam int NUM_CMP   = 3;
endpackage

// File: rtl/cmp_rst_sync.sv
module cmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/cmp_tbase_mux.sv
module cmp_tbase_mux
  import cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cnt0_i,
  input  logic         wrap0_i,
  input  logic [W-1:0] cnt1_i,
  input  logic         wrap1_i,
  input  logic         sel_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_arr  [NUM_BASES];
  logic         wrap_arr [NUM_BASES];

  assign cnt_arr[0]  = cnt0_i;
  assign cnt_arr[1]  = cnt1_i;
  assign wrap_arr[0] = wrap0_i;
  assign wrap_arr[1] = wrap1_i;

  always_comb begin
    cnt_o  = cnt_arr[sel_i];
    wrap_o = wrap_arr[sel_i];
  end
endmodule

// File: rtl/cmp_match.sv
module cmp_match
  import cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]       cnt_i,
  input  logic [W-1:0]       pri_i,
  input  logic [W-1:0]       sec_i,
  input  logic [W-1:0]       duty_i,
  output logic [NUM_CMP-1:0] hit_o
);
  logic [W-1:0] ref_v [NUM_CMP];

  assign ref_v[0] = pri_i;
  assign ref_v[1] = sec_i;
  assign ref_v[2] = duty_i;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign hit_o[i] = (cnt_i == ref_v[i]);
  end
endmodule

// File: rtl/cmp_pin_ctl.sv
module cmp_pin_ctl
  import cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] pri_i,
  input  logic         wrap_i,
  input  logic         pri_hit_i,
  input  logic         sec_hit_i,
  input  logic         duty_hit_i,
  input  logic         fault_i,
  output logic [W-1:0] duty_o,
  output logic         pin_o,
  output logic         irq_o,
  output logic         flt_o
);
  cmp_mode_e    mode_cur, mode_q;
  logic         pin_q, pin_d;
  logic         irq_q, irq_d;
  logic         flt_q, flt_d;
  logic         done_q, done_d;
  logic [W-1:0] duty_q, duty_d;
  logic         duty_en;
  logic         mode_chg;

  assign mode_cur = cmp_mode_e'(mode_i);
  assign mode_chg = (mode_cur != mode_q);

  always_comb begin
    pin_d   = pin_q;
    irq_d   = 1'b0;
    flt_d   = flt_q;
    done_d  = done_q;
    duty_d  = duty_q;
    duty_en = 1'b0;
    if (mode_chg) begin
      pin_d   = (mode_cur == MD_CLR);
      flt_d   = 1'b0;
      done_d  = 1'b0;
      duty_d  = pri_i;
      duty_en = 1'b1;
    end else begin
      case (mode_cur)
        MD_OFF: pin_d = 1'b0;
        MD_SET: if (pri_hit_i) begin pin_d = 1'b1;   irq_d = 1'b1; end
        MD_CLR: if (pri_hit_i) begin pin_d = 1'b0;   irq_d = 1'b1; end
        MD_TGL: if (pri_hit_i) begin pin_d = ~pin_q; irq_d = 1'b1; end
        MD_ONE, MD_RPT: begin
          if (!done_q) begin
            if (sec_hit_i) begin
              if (pin_q) begin
                irq_d  = 1'b1;
                done_d = (mode_cur == MD_ONE);
              end
              pin_d = 1'b0;
            end else if (pri_hit_i) begin
              pin_d = 1'b1;
            end
          end
        end
        MD_PWM, MD_PWMF: begin
          if ((mode_cur == MD_PWMF) && (fault_i || flt_q)) begin
            flt_d = 1'b1;
            pin_d = 1'b0;
          end else if (wrap_i) begin
            duty_d  = pri_i;
            duty_en = 1'b1;
            pin_d   = (pri_i != '0);
            irq_d   = 1'b1;
          end else if (duty_hit_i) begin
            pin_d = 1'b0;
          end
        end
        default: pin_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_OFF;
      pin_q  <= 1'b0;
      irq_q  <= 1'b0;
      flt_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      mode_q <= mode_cur;
      pin_q  <= pin_d;
      irq_q  <= irq_d;
      flt_q  <= flt_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       duty_q <= '0;
    else if (duty_en) duty_q <= duty_d;
  end

  assign duty_o = duty_q;
  assign pin_o  = pin_q;
  assign irq_o  = irq_q;
  assign flt_o  = flt_q;
endmodule

// File: rtl/cmp_pwm_chan.sv
module cmp_pwm_chan
  import cmp_pkg::*;
#(
  parameter int W          = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tmr0_cnt,
  input  logic         tmr0_wrap,
  input  logic [W-1:0] tmr1_cnt,
  input  logic         tmr1_wrap,
  input  logic [2:0]   mode_sel,
  input  logic         base_sel,
  input  logic [W-1:0] cmp_pri,
  input  logic [W-1:0] cmp_sec,
  input  logic         fault_in,
  output logic         pin_out,
  output logic         match_irq,
  output logic         fault_flag
);
  logic               rst_core_n;
  logic [W-1:0]       sel_cnt;
  logic               sel_wrap;
  logic [W-1:0]       duty_act;
  logic [NUM_CMP-1:0] hits;

  cmp_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  cmp_tbase_mux #(.W(W)) u_mux (
    .cnt0_i(tmr0_cnt), .wrap0_i(tmr0_wrap),
    .cnt1_i(tmr1_cnt), .wrap1_i(tmr1_wrap),
    .sel_i(base_sel), .cnt_o(sel_cnt), .wrap_o(sel_wrap)
  );

  cmp_match #(.W(W)) u_match (
    .cnt_i(sel_cnt), .pri_i(cmp_pri), .sec_i(cmp_sec),
    .duty_i(duty_act), .hit_o(hits)
  );

  cmp_pin_ctl #(.W(W)) u_ctl (
    .clk(clk), .rst_n(rst_core_n), .mode_i(mode_sel), .pri_i(cmp_pri),
    .wrap_i(sel_wrap), .pri_hit_i(hits[0]), .sec_hit_i(hits[1]),
    .duty_hit_i(hits[2]), .fault_i(fault_in), .duty_o(duty_act),
    .pin_o(pin_out), .irq_o(match_irq), .flt_o(fault_flag)
  );
endmodule

// File: rtl/cmp_pwm_chk.sv
module cmp_pwm_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_core_n,
  input logic [2:0]   mode_sel,
  input logic [W-1:0] cmp_pri,
  input logic         pin_out,
  input logic         match_irq,
  input logic         fault_flag
);
  logic [2:0] prev_mode;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) prev_mode <= 3'b000;
    else             prev_mode <= mode_sel;
  end

  // R2: off mode drives a low, quiet pin
  p_off_low_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_sel == 3'b000) |=> (!pin_out && !match_irq));

  // R3: entering drive-low starts high
  p_init_high_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_sel == 3'b010 && prev_mode != 3'b010) |=> pin_out);

  // R4: a set pin stays set while drive-high runs
  p_set_hold_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_sel == 3'b001 && prev_mode == 3'b001 && pin_out) |=> pin_out);

  // R5: a cleared pin stays cleared while drive-low runs
  p_clr_hold_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_sel == 3'b010 && prev_mode == 3'b010 && !pin_out) |=> !pin_out);

  // R9: zero duty keeps the pin low
  p_zero_duty_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_sel == 3'b110 && prev_mode == 3'b110 && cmp_pri == '0 && !pin_out) |=> !pin_out);

  // R11: fault flag forces the pin low and persists while the mode holds
  p_fault_low_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    fault_flag |-> !pin_out);

  p_fault_sticky_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (fault_flag && mode_sel == 3'b111) |=> fault_flag);
endmodule

bind cmp_pwm_chan cmp_pwm_chk #(.W(W)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .mode_sel(mode_sel), .cmp_pri(cmp_pri),
  .pin_out(pin_out), .match_irq(match_irq), .fault_flag(fault_flag)
);

// File: tb/cmp_pwm_chan_tb_top.sv
`timescale 1ns/1ps
module cmp_pwm_chan_tb_top;
  localparam int W     = 8;
  localparam int PER_A = 19;
  localparam int PER_B = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] cnt_a, cnt_b;
  logic         wrap_a, wrap_b;
  logic [2:0]   mode;
  logic         bsel;
  logic [W-1:0] pri, sec;
  logic         fault;
  logic         pin, irq, flt;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  finished = 0;

  logic [2:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  cmp_pwm_chan #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tmr0_cnt(cnt_a), .tmr0_wrap(wrap_a),
    .tmr1_cnt(cnt_b), .tmr1_wrap(wrap_b), .mode_sel(mode), .base_sel(bsel),
    .cmp_pri(pri), .cmp_sec(sec), .fault_in(fault),
    .pin_out(pin), .match_irq(irq), .fault_flag(flt)
  );

  // free-running time bases, advanced on falling edges
  assign wrap_a = (cnt_a == W'(PER_A));
  assign wrap_b = (cnt_b == W'(PER_B));
  always @(negedge clk) begin
    if (!rst_n) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else begin
      cnt_a <= wrap_a ? '0 : cnt_a + 1'b1;
      cnt_b <= wrap_b ? '0 : cnt_b + 1'b1;
    end
  end

  task automatic check3(input logic [2:0] act, input logic [2:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pin/irq/flt actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // predictor: expected outputs written from the requirements
  logic         m_pin, m_irq, m_flt, m_done;
  logic [2:0]   m_mode;
  logic [W-1:0] m_duty;

  function automatic string tag_of(input logic [2:0] md, input logic chg, input logic bs);
    string s;
    if (chg) s = "R3";
    else case (md)
      3'd0: s = "R2";
      3'd1: s = "R4";
      3'd2: s = "R5";
      3'd3: s = "R6";
      3'd4: s = "R7 R8";
      3'd5: s = "R7 R8";
      3'd6: s = "R9 R10";
      default: s = "R11";
    endcase
    return bs ? {s, " R1"} : s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pin = 0; m_irq = 0; m_flt = 0; m_done = 0; m_mode = 0; m_duty = 0;
    end else begin
      logic [W-1:0] c;
      logic         wr, chg;
      c   = bsel ? cnt_b : cnt_a;
      wr  = bsel ? wrap_b : wrap_a;
      chg = (mode != m_mode);
      m_irq = 0;
      if (chg) begin
        m_pin = (mode == 3'd2); m_flt = 0; m_done = 0; m_duty = pri;
      end else if (mode == 3'd0) begin
        m_pin = 0;
      end else if (mode <= 3'd3) begin
        if (c == pri) begin
          m_irq = 1;
          m_pin = (mode == 3'd1) ? 1'b1 : (mode == 3'd2) ? 1'b0 : ~m_pin;
        end
      end else if (mode <= 3'd5) begin
        if (!m_done) begin
          if (c == sec) begin
            if (m_pin) begin m_irq = 1; m_done = (mode == 3'd4); end
            m_pin = 0;
          end else if (c == pri) m_pin = 1;
        end
      end else begin
        if (mode == 3'd7 && (fault || m_flt)) begin
          m_flt = 1; m_pin = 0;
        end else if (wr) begin
          m_duty = pri; m_pin = (pri != 0); m_irq = 1;
        end else if (c == m_duty) m_pin = 0;
      end
      m_mode = mode;
      exp_q.push_back({m_pin, m_irq, m_flt});
      tag_q.push_back(tag_of(mode, chg, bsel));
    end
  end

  // monitor: compare one registered stage after each prediction
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check3({pin, irq, flt}, e, t);
    end
  end

  task automatic drive(input logic [2:0] md, input logic bs,
                       input logic [W-1:0] p, input logic [W-1:0] s);
    @(negedge clk);
    mode = md; bsel = bs; pri = p; sec = s;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    rst_n = 0; mode = 0; bsel = 0; pri = 0; sec = 0; fault = 0;
    run(3);
    check3({pin, irq, flt}, 3'b000, "R2 reset");
    rst_n = 1;
    run(6);
    drive(3'd1, 0, 8'd5, 8'd0);  run(50);   // R4
    drive(3'd0, 0, 8'd5, 8'd0);  run(4);    // R2
    drive(3'd2, 0, 8'd7, 8'd0);  run(45);   // R5, R3 high start
    drive(3'd0, 0, 8'd7, 8'd0);  run(3);
    drive(3'd3, 1, 8'd4, 8'd0);  run(40);   // R6 on base B, R1
    drive(3'd3, 0, 8'd4, 8'd0);  run(45);   // R1 switch to base A
    drive(3'd4, 0, 8'd3, 8'd9);  run(65);   // R8 single pulse
    drive(3'd5, 0, 8'd3, 8'd9);  run(65);   // R8 repeating
    drive(3'd5, 1, 8'd2, 8'd8);  run(40);   // R7 on base B
    drive(3'd5, 0, 8'd6, 8'd6);  run(45);   // R7 both match same clock
    drive(3'd6, 0, 8'd6, 8'd0);  run(45);   // R9
    run(5);
    drive(3'd6, 0, 8'd10, 8'd0); run(45);   // R10 new duty at next strobe
    drive(3'd6, 0, 8'd0, 8'd0);  run(45);   // R9 zero duty
    drive(3'd6, 0, 8'd25, 8'd0); run(45);   // duty beyond period
    drive(3'd7, 0, 8'd8, 8'd0);  run(30);   // R11 normal PWM
    @(negedge clk); fault = 1;
    @(negedge clk); fault = 0;
    run(45);                                // R11 sticky
    drive(3'd6, 0, 8'd8, 8'd0);  run(3);
    drive(3'd7, 0, 8'd8, 8'd0);  run(45);   // R11 resumes after rewrite
    run(2);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule